// File: doc/BRIEF.md
# SPI Transfer Sequencer

This block holds the control registers that govern one SPI master transfer and steps the shift engine through it. Software programs a transmit word count and a receive word count, each split across a high and a low register, and chooses the transfer direction. It then starts the transfer in one of three ways: by writing the direction field (standard four-wire operation), by a software request (three-wire or dual-line operation), or by arming the receive-only self-clocking counter. The engine reports every word it takes from the transmit FIFO and every word it writes into the receive FIFO. The sequencer counts these reports down and raises an end event for each direction when its count runs out.

Each end event is latched in a raw status register. Software clears it by writing a one to a clear register, and an enable register masks it onto a single interrupt line. When DMA is enabled, the sequencer pulses a request strobe at each fragment boundary. On the transmit side this means there is room for another fragment. On the receive side it means a fragment, or the final partial fragment, is ready.

Top module: `spi_xfer_seq`

## Requirements
- R1: The transmit length is {high register at address 0 bits [3:0], low register at address 1 bits [15:0]}, and the receive length uses addresses 2 and 3 in the same way. Unused high bits read back as zero. A started transfer raises its end event on exactly the word whose count equals this length, and not before.
- R2: The control register (address 4) holds the direction in bit 1 (transmit) and bit 0 (receive). With bits 2 and 3 clear, writing a nonzero direction reloads the chosen counters and pulses eng_start_o in the next cycle. The run outputs follow the counters being nonzero. Writing a zero direction drops both counters to zero, and later word reports raise no event.
- R3: With control bit 2 (three-wire) or bit 3 (dual-line) set, a direction write starts nothing. A write to address 5 starts a transmit with bit 1 and a receive with bit 0, and each takes effect only when the matching direction bit is set.
- R4: The self-clocking register (address 6) holds a 9-bit count in bits [8:0] and an arm bit in bit 9. When the stored arm bit is 0, the direction is receive-only and the control is in standard mode, a write with bit 9 set loads the receive counter with the count. A write with bit 9 clear starts nothing. eng_self_clk_o is high while the arm bit is set and receive words remain.
- R5: Raw status (address 9) bit 8 sets when the last transmit word is reported, and bit 9 sets when the last receive word is reported. Both set on the same edge at which the counter reaches zero.
- R6: Writing ones to address 8 at bits 8/9 clears those raw bits. If a clear and a set of the same bit fall in one cycle, the bit ends set.
- R7: Masked status (address 10) is raw ANDed with the enable register (address 7, bits 8/9), and irq_o is the OR of the masked bits.
- R8: A counter at zero stays at zero. Further word reports change neither the run outputs nor the raw status.
- R9: With control bit 4 set, dma_tx_req_o pulses the cycle after a transmit start with a nonzero count, and after every FRAG-th transmitted word while words remain. dma_rx_req_o pulses after every FRAG-th received word and after the last received word.
- R10: After reset every register reads zero and irq_o, eng_start_o, both run outputs, eng_self_clk_o and both DMA strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| eng_tx_word_i | input | 1 | Engine took one word from the transmit FIFO |
| eng_rx_word_i | input | 1 | Engine wrote one word into the receive FIFO |
| eng_start_o | output | 1 | One-cycle pulse: a transfer was (re)started |
| eng_tx_run_o | output | 1 | Transmit words remain |
| eng_rx_run_o | output | 1 | Receive words remain |
| eng_self_clk_o | output | 1 | Engine should clock receive words on its own |
| dma_tx_req_o | output | 1 | Transmit fragment request strobe |
| dma_rx_req_o | output | 1 | Receive fragment request strobe |
| irq_o | output | 1 | Interrupt, OR of masked status |

## Verification
The bench builds the block with the default field widths (4-bit high part, 16-bit low part, 9-bit self-clocking count) and overrides FRAG to 4. With that fragment size, several DMA boundaries fall inside transfers of six to ten words, including a final partial receive fragment. The default widths keep a transmit length with a nonzero high part, and so a true 20-bit count, within about 65 thousand cycles, and the bench runs one such transfer to its end.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] A_TXH  = 4'd0;
   localparam logic [REG_AW-1:0] A_TXL  = 4'd1;
   localparam logic [REG_AW-1:0] A_RXH  = 4'd2;
   localparam logic [REG_AW-1:0] A_RXL  = 4'd3;
   localparam logic [REG_AW-1:0] A_CTRL = 4'd4;
   localparam logic [REG_AW-1:0] A_SREQ = 4'd5;
   localparam logic [REG_AW-1:0] A_AUTO = 4'd6;
   localparam logic [REG_AW-1:0] A_IEN  = 4'd7;
   localparam logic [REG_AW-1:0] A_ICLR = 4'd8;
   localparam logic [REG_AW-1:0] A_IRAW = 4'd9;
   localparam logic [REG_AW-1:0] A_IMSK = 4'd10;

   // event bit positions in the status registers (index 0 = transmit)
   localparam int EVT_LSB = 8;
   localparam int EVT_MSB = 9;
   localparam int NUM_CH  = 2;

   typedef struct packed {
      logic dma;
      logic dual;
      logic wire3;
      logic tx;
      logic rx;
   } ctrl_t;
endpackage

// File: rtl/spi_seq_chan.sv
module spi_seq_chan #(
   parameter int LEN_W   = 20,
   parameter int FRAG    = 8,
   parameter bit RX_SIDE = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [LEN_W-1:0] load_val_i,
   input  logic             clear_i,
   input  logic             word_i,
   input  logic             dma_en_i,
   output logic             run_o,
   output logic             end_o,
   output logic             dma_req_o
);
   localparam int FRAG_W = (FRAG > 1) ? $clog2(FRAG) : 1;

   if (FRAG < 1) begin : g_bad_frag
      $error("spi_seq_chan: FRAG must be at least 1");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("spi_seq_chan: LEN_W must be at least 2");
   end

   logic [LEN_W-1:0]  cnt_q;
   logic [FRAG_W-1:0] frag_q;
   logic              req_q;
   logic              req_d;
   logic              word_ok;
   logic              last_w;
   logic              frag_wrap;

   assign word_ok   = word_i && (cnt_q != '0) && !load_i && !clear_i;
   assign last_w    = (cnt_q == LEN_W'(1));
   assign frag_wrap = (frag_q == FRAG_W'(FRAG - 1));

   if (RX_SIDE) begin : g_rx_req
      assign req_d = dma_en_i && word_ok && (frag_wrap || last_w);
   end else begin : g_tx_req
      assign req_d = dma_en_i &&
                     ((load_i && !clear_i && (load_val_i != '0)) ||
                      (word_ok && !last_w && frag_wrap));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         frag_q <= '0;
         req_q  <= 1'b0;
      end else begin
         req_q <= req_d;
         if (clear_i) begin
            cnt_q  <= '0;
            frag_q <= '0;
         end else if (load_i) begin
            cnt_q  <= load_val_i;
            frag_q <= '0;
         end else if (word_ok) begin
            cnt_q  <= cnt_q - LEN_W'(1);
            frag_q <= frag_wrap ? '0 : frag_q + FRAG_W'(1);
         end
      end
   end

   assign run_o     = (cnt_q != '0);
   assign end_o     = word_ok && last_w;
   assign dma_req_o = req_q;

   a_r8_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
   a_r5_end_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_o |=> (cnt_q == '0));
   a_r1_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !clear_i) |=> (cnt_q == $past(load_val_i)));
   a_r9_req_needs_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o |-> $past(dma_en_i));
endmodule

// File: rtl/spi_seq_irq.sv
module spi_seq_irq #(
   parameter int NEV = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NEV-1:0] set_i,
   input  logic [NEV-1:0] clr_i,
   input  logic [NEV-1:0] en_i,
   output logic [NEV-1:0] raw_o,
   output logic [NEV-1:0] masked_o,
   output logic           irq_o
);
   if (NEV < 1) begin : g_bad_nev
      $error("spi_seq_irq: NEV must be at least 1");
   end

   logic [NEV-1:0] raw_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q <= '0;
      else         raw_q <= (raw_q & ~clr_i) | set_i;
   end

   assign raw_o    = raw_q;
   assign masked_o = raw_q & en_i;
   assign irq_o    = |masked_o;

   a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));
   a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~set_i) != '0) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
   import spi_seq_pkg::*;
#(
   parameter int LEN_HI_W = 4,
   parameter int LEN_LO_W = 16,
   parameter int AUTO_W   = 9,
   parameter int FRAG     = 8,
   parameter int DATA_W   = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [REG_AW-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              eng_tx_word_i,
   input  logic              eng_rx_word_i,
   output logic              eng_start_o,
   output logic              eng_tx_run_o,
   output logic              eng_rx_run_o,
   output logic              eng_self_clk_o,
   output logic              dma_tx_req_o,
   output logic              dma_rx_req_o,
   output logic              irq_o
);
   localparam int LEN_W = LEN_HI_W + LEN_LO_W;

   if (DATA_W < LEN_LO_W || DATA_W <= EVT_MSB || DATA_W <= AUTO_W) begin : g_bad_data
      $error("spi_xfer_seq: DATA_W too narrow for the register fields");
   end
   if (AUTO_W > LEN_W) begin : g_bad_auto
      $error("spi_xfer_seq: AUTO_W must not exceed the length width");
   end

   logic [LEN_HI_W-1:0] txh_q, rxh_q;
   logic [LEN_LO_W-1:0] txl_q, rxl_q;
   ctrl_t               ctrl_q;
   logic [AUTO_W-1:0]   auto_cnt_q;
   logic                auto_go_q;
   logic [NUM_CH-1:0]   ien_q;
   logic                start_q;

   logic wr_ctrl, wr_sreq, wr_auto, wr_clr;
   ctrl_t new_ctrl;
   logic new_sw, cur_sw, go_idle, auto_load, dma_eff;

   logic [NUM_CH-1:0]             ch_load, ch_word, ch_run, ch_end, ch_req;
   logic [NUM_CH-1:0][LEN_W-1:0]  ch_val;
   logic [NUM_CH-1:0]             raw_w, msk_w, clr_w;
   wire                           unused_wdata = ^bus_wdata_i;

   assign wr_ctrl  = bus_we_i && (bus_addr_i == A_CTRL);
   assign wr_sreq  = bus_we_i && (bus_addr_i == A_SREQ);
   assign wr_auto  = bus_we_i && (bus_addr_i == A_AUTO);
   assign wr_clr   = bus_we_i && (bus_addr_i == A_ICLR);
   assign new_ctrl = ctrl_t'(bus_wdata_i[4:0]);
   assign new_sw   = new_ctrl.wire3 || new_ctrl.dual;
   assign cur_sw   = ctrl_q.wire3 || ctrl_q.dual;
   assign go_idle  = wr_ctrl && !new_ctrl.tx && !new_ctrl.rx;
   assign dma_eff  = wr_ctrl ? new_ctrl.dma : ctrl_q.dma;

   assign auto_load = wr_auto && bus_wdata_i[AUTO_W] && !auto_go_q &&
                      ctrl_q.rx && !ctrl_q.tx && !cur_sw;

   assign ch_load[0] = (wr_ctrl && !new_sw && new_ctrl.tx) ||
                       (wr_sreq && cur_sw && ctrl_q.tx && bus_wdata_i[1]);
   assign ch_load[1] = (wr_ctrl && !new_sw && new_ctrl.rx) ||
                       (wr_sreq && cur_sw && ctrl_q.rx && bus_wdata_i[0]) ||
                       auto_load;
   assign ch_val[0]  = {txh_q, txl_q};
   assign ch_val[1]  = auto_load ? LEN_W'(bus_wdata_i[AUTO_W-1:0]) : {rxh_q, rxl_q};
   assign ch_word[0] = eng_tx_word_i;
   assign ch_word[1] = eng_rx_word_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         txh_q      <= '0;
         txl_q      <= '0;
         rxh_q      <= '0;
         rxl_q      <= '0;
         ctrl_q     <= '0;
         auto_cnt_q <= '0;
         auto_go_q  <= 1'b0;
         ien_q      <= '0;
         start_q    <= 1'b0;
      end else begin
         start_q <= |ch_load;
         if (bus_we_i) begin
            case (bus_addr_i)
               A_TXH:   txh_q  <= bus_wdata_i[LEN_HI_W-1:0];
               A_TXL:   txl_q  <= bus_wdata_i[LEN_LO_W-1:0];
               A_RXH:   rxh_q  <= bus_wdata_i[LEN_HI_W-1:0];
               A_RXL:   rxl_q  <= bus_wdata_i[LEN_LO_W-1:0];
               A_CTRL:  ctrl_q <= new_ctrl;
               A_AUTO: begin
                  auto_cnt_q <= bus_wdata_i[AUTO_W-1:0];
                  auto_go_q  <= bus_wdata_i[AUTO_W];
               end
               A_IEN:   ien_q  <= bus_wdata_i[EVT_MSB:EVT_LSB];
               default: ;
            endcase
         end
      end
   end

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      spi_seq_chan #(
         .LEN_W   (LEN_W),
         .FRAG    (FRAG),
         .RX_SIDE (gi == 1)
      ) i_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .load_i     (ch_load[gi]),
         .load_val_i (ch_val[gi]),
         .clear_i    (go_idle),
         .word_i     (ch_word[gi]),
         .dma_en_i   (dma_eff),
         .run_o      (ch_run[gi]),
         .end_o      (ch_end[gi]),
         .dma_req_o  (ch_req[gi])
      );
   end

   assign clr_w = wr_clr ? bus_wdata_i[EVT_MSB:EVT_LSB] : '0;

   spi_seq_irq #(.NEV(NUM_CH)) i_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (ch_end),
      .clr_i    (clr_w),
      .en_i     (ien_q),
      .raw_o    (raw_w),
      .masked_o (msk_w),
      .irq_o    (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_TXH:   bus_rdata_o = DATA_W'(txh_q);
         A_TXL:   bus_rdata_o = DATA_W'(txl_q);
         A_RXH:   bus_rdata_o = DATA_W'(rxh_q);
         A_RXL:   bus_rdata_o = DATA_W'(rxl_q);
         A_CTRL:  bus_rdata_o = DATA_W'(ctrl_q);
         A_AUTO:  bus_rdata_o = DATA_W'({auto_go_q, auto_cnt_q});
         A_IEN:   bus_rdata_o = DATA_W'(ien_q) << EVT_LSB;
         A_IRAW:  bus_rdata_o = DATA_W'(raw_w) << EVT_LSB;
         A_IMSK:  bus_rdata_o = DATA_W'(msk_w) << EVT_LSB;
         default: bus_rdata_o = '0;
      endcase
   end

   assign eng_start_o    = start_q;
   assign eng_tx_run_o   = ch_run[0];
   assign eng_rx_run_o   = ch_run[1];
   assign eng_self_clk_o = auto_go_q && ch_run[1];
   assign dma_tx_req_o   = ch_req[0];
   assign dma_rx_req_o   = ch_req[1];

   a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_idle |=> (!eng_tx_run_o && !eng_rx_run_o));
   a_r3_no_direct_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == A_CTRL && (bus_wdata_i[2] || bus_wdata_i[3]))
      |=> !eng_start_o);
   a_r7_irq_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/test_spi_xfer_seq.sv
`timescale 1ns/1ps
module test_spi_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tx_word = 1'b0;
   logic        rx_word = 1'b0;
   logic        e_start, e_txrun, e_rxrun, e_self, d_tx, d_rx, irq;

   int total = 0;
   int bad = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   spi_xfer_seq #(.FRAG(4)) i_spi_xfer_seq (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .eng_tx_word_i(tx_word), .eng_rx_word_i(rx_word),
      .eng_start_o(e_start), .eng_tx_run_o(e_txrun), .eng_rx_run_o(e_rxrun),
      .eng_self_clk_o(e_self), .dma_tx_req_o(d_tx), .dma_rx_req_o(d_rx),
      .irq_o(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic words(input bit rx, input int n);
      @(negedge clk);
      if (rx) rx_word = 1'b1; else tx_word = 1'b1;
      repeat (n) @(negedge clk);
      rx_word = 1'b0; tx_word = 1'b0;
   endtask

   // scoreboard monitor: strobe code {start, tx req, rx req}
   always @(negedge clk) begin
      if (rst_n && (e_start || d_tx || d_rx)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2/R3/R9 unexpected strobe", {e_start, d_tx, d_rx}, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk({e_start, d_tx, d_rx} == 3'(e), "R2/R3/R9 strobe",
                {e_start, d_tx, d_rx}, e);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "R10 watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      rd(4'd4, v);  chk(v == 0, "R10 ctrl reset", v, 0);
      rd(4'd9, v);  chk(v == 0, "R10 raw reset", v, 0);
      chk({irq, e_start, e_txrun, e_rxrun, e_self, d_tx, d_rx} == 0,
          "R10 outputs reset", {irq, e_start, e_txrun, e_rxrun, e_self, d_tx, d_rx}, 0);

      // R1 readback masking
      wr(4'd0, 32'hFFF5); rd(4'd0, v); chk(v == 5, "R1 high part mask", v, 5);
      wr(4'd0, 0);
      wr(4'd1, 32'h3_000A); rd(4'd1, v); chk(v == 10, "R1 low part mask", v, 10);

      // transmit of 10 words with DMA
      exp_q.push_back(6);
      wr(4'd4, 32'h12);
      chk(e_txrun == 1, "R2 tx run after start", e_txrun, 1);
      exp_q.push_back(2); exp_q.push_back(2);
      words(0, 9);
      rd(4'd9, v); chk(v == 0, "R1 no end before count", v, 0);
      words(0, 1);
      rd(4'd9, v); chk(v == 32'h100, "R5 tx end raw", v, 32'h100);
      chk(e_txrun == 0, "R5 tx run low at end", e_txrun, 0);

      // R7 masking
      chk(irq == 0, "R7 irq masked", irq, 0);
      wr(4'd7, 32'h100);
      chk(irq == 1, "R7 irq enabled", irq, 1);
      rd(4'd10, v); chk(v == 32'h100, "R7 masked status", v, 32'h100);

      // R6 clear
      wr(4'd8, 32'h100);
      rd(4'd9, v); chk(v == 0, "R6 w1c clears", v, 0);
      chk(irq == 0, "R6 irq after clear", irq, 0);

      // R8 counter floor
      words(0, 3);
      rd(4'd9, v); chk(v == 0, "R8 no event at zero", v, 0);
      chk(e_txrun == 0, "R8 run stays low", e_txrun, 0);

      // receive of 6 words with DMA
      wr(4'd3, 6);
      exp_q.push_back(4);
      wr(4'd4, 32'h11);
      exp_q.push_back(1); exp_q.push_back(1);
      words(1, 6);
      rd(4'd9, v); chk(v == 32'h200, "R5 rx end raw", v, 32'h200);
      chk(irq == 0, "R7 rx bit not enabled", irq, 0);
      rd(4'd10, v); chk(v == 0, "R7 masked excludes rx", v, 0);
      wr(4'd8, 32'h300);

      // R2 return to idle
      wr(4'd1, 5);
      exp_q.push_back(4);
      wr(4'd4, 32'h02);
      words(0, 2);
      wr(4'd4, 0);
      chk(e_txrun == 0, "R2 idle clears run", e_txrun, 0);
      words(0, 5);
      rd(4'd9, v); chk(v == 0, "R2 idle no event", v, 0);

      // R3 three-wire: software request
      wr(4'd4, 32'h06);
      chk(e_txrun == 0, "R3 direction write no start", e_txrun, 0);
      wr(4'd5, 32'h1);
      chk({e_txrun, e_rxrun} == 0, "R3 rx req without rx dir", {e_txrun, e_rxrun}, 0);
      exp_q.push_back(4);
      wr(4'd5, 32'h2);
      chk(e_txrun == 1, "R3 tx req starts", e_txrun, 1);
      words(0, 5);
      rd(4'd9, v); chk(v == 32'h100, "R3 tx end after req", v, 32'h100);
      wr(4'd8, 32'h100);
      // R3 dual-line receive
      wr(4'd3, 2);
      wr(4'd4, 32'h09);
      chk(e_rxrun == 0, "R3 dual no direct start", e_rxrun, 0);
      exp_q.push_back(4);
      wr(4'd5, 32'h1);
      chk(e_rxrun == 1, "R3 dual rx req starts", e_rxrun, 1);
      words(1, 2);
      rd(4'd9, v); chk(v == 32'h200, "R3 dual rx end", v, 32'h200);
      wr(4'd8, 32'h300);

      // R4 self-clocking receive
      wr(4'd3, 0);
      exp_q.push_back(4);
      wr(4'd4, 32'h01);
      chk(e_rxrun == 0, "R4 zero length idle", e_rxrun, 0);
      wr(4'd6, 32'h003);
      chk({e_rxrun, e_self} == 0, "R4 count alone no start", {e_rxrun, e_self}, 0);
      rd(4'd6, v); chk(v == 3, "R4 count readback", v, 3);
      exp_q.push_back(4);
      wr(4'd6, 32'h203);
      chk({e_rxrun, e_self} == 2'b11, "R4 armed start", {e_rxrun, e_self}, 3);
      words(1, 2);
      rd(4'd9, v); chk(v == 0, "R4 not done after 2", v, 0);
      words(1, 1);
      rd(4'd9, v); chk(v == 32'h200, "R4 end after count", v, 32'h200);
      chk(e_self == 0, "R4 self clock stops", e_self, 0);
      wr(4'd6, 32'h203);
      chk(e_rxrun == 0, "R4 held arm no restart", e_rxrun, 0);
      wr(4'd8, 32'h300);

      // R6 set wins over clear
      wr(4'd6, 0);
      wr(4'd3, 1);
      exp_q.push_back(4);
      wr(4'd4, 32'h01);
      @(negedge clk);
      we = 1'b1; addr = 4'd8; wdata = 32'h200; rx_word = 1'b1;
      @(negedge clk);
      we = 1'b0; rx_word = 1'b0;
      rd(4'd9, v); chk(v == 32'h200, "R6 set wins", v, 32'h200);
      wr(4'd8, 32'h200);
      rd(4'd9, v); chk(v == 0, "R6 later clear", v, 0);

      // R1 full 20-bit length
      wr(4'd0, 1); wr(4'd1, 2);
      exp_q.push_back(4);
      wr(4'd4, 32'h02);
      words(0, 65537);
      rd(4'd9, v); chk(v == 0, "R1 20-bit not early", v, 0);
      words(0, 1);
      rd(4'd9, v); chk(v == 32'h100, "R1 20-bit end", v, 32'h100);

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R9 all strobes seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule